// File: doc/BRIEF.md
# Variable-Length Instruction Word Assembler

This block sits between an instruction memory and the execute stage of a small 16-bit processor with a 24-bit word address space. Each cycle that the fetch path is not stalled, it takes one 16-bit word from the address it drives, and it advances that address by one. The first word of each instruction carries an 8-bit operation code, a 4-bit register-or-flag number and a 4-bit source register number. From the operation code alone the block knows whether zero, one or two extension words follow. It collects them and then presents the whole instruction on a set of registered outputs, qualified by a single-cycle valid pulse.

An instruction that uses one extension word carries a 16-bit operand. The block treats that operand as a sector-local address: the upper 8 bits of the target come from the address of the instruction's first word, so the target stays in that 64K-word sector. An instruction that uses two extension words carries a full address. The low 8 bits of the first extension word give the upper address byte, and the second extension word gives the lower 16 bits. The block only fetches and decodes. Executing the instruction, and redirecting the fetch address after a jump, are left to the stages that consume its outputs.

The control is a three-state machine. OPCODE waits for a first word. EXT1 waits for the first extension word. EXT2 waits for the second extension word. The transitions are:
- OPCODE to OPCODE when a one-word instruction is taken.
- OPCODE to EXT1 when a longer instruction is taken.
- EXT1 to OPCODE when a two-word instruction completes.
- EXT1 to EXT2 when a three-word instruction continues.
- EXT2 to OPCODE when it completes.

While the stall input is high, every state holds.

Top module: `insn_assembler`

## Requirements
- R1: While reset is asserted and after it is released, `fetch_addr_o` equals parameter `RESET_PC` and `dec_vld_o` is low until the first instruction completes.
- R2: On every clock edge where `fetch_stall_i` is low, the word on `fetch_word_i` is taken and `fetch_addr_o` increases by one, modulo 2^24.
- R3: On a clock edge where `fetch_stall_i` is high, no word is taken, and the fetch address and the machine state hold. The cycle after that edge shows no valid pulse.
- R4: A decoded instruction reports the following fields:
  - `dec_opcode_o` is bits 15..8 of its first word.
  - `dec_rf_o` is bits 7..4 of its first word.
  - `dec_rs_o` is bits 3..0 of its first word.
  - `dec_pc_o` is the address that first word was fetched from.
- R5: Operation codes 0x08, 0x0C, 0x10, 0x80 through 0x89, 0xC0 and 0xC4 are two words long, and `dec_len_o` reports 2.
- R6: Operation codes 0x09, 0x11, 0xC1 and 0xC5 are three words long, and `dec_len_o` reports 3.
- R7: Every other operation code, including unassigned ones, is one word long, and `dec_len_o` reports 1.
- R8: `dec_vld_o` is high for exactly one cycle, the cycle after the edge that takes the last word of the instruction. Unstalled instructions therefore complete at intervals equal to their word count, and one-word instructions complete on consecutive cycles.
- R9: For a two-word instruction, `dec_imm_o` is the extension word. `dec_target_o` is the top 8 bits of `dec_pc_o` joined to that word, even when the extension word itself lies in the next sector. `dec_global_o` is low.
- R10: For a three-word instruction, `dec_target_o` is bits 7..0 of the first extension word joined to the second extension word. Bits 15..8 of the first extension word have no effect. `dec_imm_o` is the second extension word, and `dec_global_o` is high.
- R11: For a one-word instruction, `dec_target_o` and `dec_imm_o` are zero and `dec_global_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word_i | input | 16 | Instruction word stored at `fetch_addr_o` |
| fetch_stall_i | input | 1 | Do not take a word this cycle; hold all state |
| fetch_addr_o | output | 24 | Address of the next word to take |
| dec_vld_o | output | 1 | One-cycle pulse: the decoded fields are new |
| dec_opcode_o | output | 8 | Operation code |
| dec_rf_o | output | 4 | Register or flag number |
| dec_rs_o | output | 4 | Source register number |
| dec_len_o | output | 2 | Instruction length in words (1 to 3) |
| dec_imm_o | output | 16 | Last extension word, or zero |
| dec_target_o | output | 24 | Formed target address, or zero |
| dec_global_o | output | 1 | Target came from a full 24-bit address |
| dec_pc_o | output | 24 | Address of the instruction's first word |

## Verification
The bench keeps the default word and address widths but overrides `RESET_PC` to 0x03FFFE. The program starts two words below a 64K-word sector boundary, so a two-word instruction has its first word at 0x03FFFF and its operand at 0x040000. That reaches the case where the local target must take its upper byte from the first word's address and not from the address of the operand. The program also places a full-address instruction whose upper address word has bits 15..8 set, an unassigned operation code, and a stall that lands between the first and second words of a three-word instruction.

// File: rtl/insn_asm_pkg.sv
package insn_asm_pkg;

    localparam int OPC_W = 8;
    localparam int REG_W = 4;

    typedef enum logic [1:0] {
        LEN_ONE   = 2'd1,
        LEN_TWO   = 2'd2,
        LEN_THREE = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_EXT1   = 2'd1,
        ST_EXT2   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/insn_len_decode.sv
module insn_len_decode
    import insn_asm_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output len_e             len_o
);

    always_comb begin
        case (opcode_i) inside
            8'h08, 8'h0C, 8'h10,
            [8'h80:8'h89],
            8'hC0, 8'hC4:                 len_o = LEN_TWO;
            8'h09, 8'h11, 8'hC1, 8'hC5:   len_o = LEN_THREE;
            default:                      len_o = LEN_ONE;
        endcase
    end

endmodule

// File: rtl/insn_seq_fsm.sv
module insn_seq_fsm
    import insn_asm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance_i,
    input  len_e op_len_i,
    output logic in_opcode_o,
    output logic take_ext1_o,
    output logic done_o,
    output len_e cur_len_o
);

    seq_state_e state_q, state_d;
    len_e       len_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            len_q   <= LEN_ONE;
        end else begin
            state_q <= state_d;
            if (advance_i && state_q == ST_OPCODE) begin
                len_q <= op_len_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: begin
                if (advance_i && op_len_i != LEN_ONE) begin
                    state_d = ST_EXT1;
                end
            end
            ST_EXT1: begin
                if (advance_i) begin
                    state_d = (len_q == LEN_THREE) ? ST_EXT2 : ST_OPCODE;
                end
            end
            ST_EXT2: begin
                if (advance_i) begin
                    state_d = ST_OPCODE;
                end
            end
            default: state_d = ST_OPCODE;
        endcase
    end

    // outputs
    always_comb begin
        in_opcode_o = 1'b0;
        take_ext1_o = 1'b0;
        done_o      = 1'b0;
        cur_len_o   = len_q;
        unique case (state_q)
            ST_OPCODE: begin
                in_opcode_o = 1'b1;
                cur_len_o   = op_len_i;
                done_o      = advance_i && (op_len_i == LEN_ONE);
            end
            ST_EXT1: begin
                take_ext1_o = advance_i;
                done_o      = advance_i && (len_q == LEN_TWO);
            end
            ST_EXT2: begin
                done_o      = advance_i;
            end
            default: begin
                in_opcode_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/insn_pc_ctr.sv
module insn_pc_ctr #(
    parameter int              PC_W     = 24,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(1);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (advance_i) begin
            pc_q <= pc_q + STEP;
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/insn_target_form.sv
module insn_target_form
    import insn_asm_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int WORD_W = 16
) (
    input  len_e              len_i,
    input  logic [PC_W-1:0]   pc0_i,
    input  logic [WORD_W-1:0] ext1_i,
    input  logic [WORD_W-1:0] ext2_i,
    output logic [PC_W-1:0]   target_o,
    output logic [WORD_W-1:0] imm_o,
    output logic              global_o
);

    localparam int PAGE_W = PC_W - WORD_W;

    logic [PAGE_W-1:0] page_local;
    logic [PAGE_W-1:0] page_global;

    assign page_local  = pc0_i[PC_W-1 -: PAGE_W];
    assign page_global = ext1_i[PAGE_W-1:0];

    always_comb begin
        target_o = '0;
        imm_o    = '0;
        global_o = 1'b0;
        unique case (len_i)
            LEN_TWO: begin
                target_o = {page_local, ext1_i};
                imm_o    = ext1_i;
            end
            LEN_THREE: begin
                target_o = {page_global, ext2_i};
                imm_o    = ext2_i;
                global_o = 1'b1;
            end
            default: begin
                target_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/insn_assembler.sv
module insn_assembler
    import insn_asm_pkg::*;
#(
    parameter int              PC_W     = 24,
    parameter int              WORD_W   = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fetch_word_i,
    input  logic              fetch_stall_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              dec_vld_o,
    output logic [OPC_W-1:0]  dec_opcode_o,
    output logic [REG_W-1:0]  dec_rf_o,
    output logic [REG_W-1:0]  dec_rs_o,
    output logic [1:0]        dec_len_o,
    output logic [WORD_W-1:0] dec_imm_o,
    output logic [PC_W-1:0]   dec_target_o,
    output logic              dec_global_o,
    output logic [PC_W-1:0]   dec_pc_o
);

    logic advance;
    logic in_opcode, take_ext1, done;
    len_e op_len, cur_len;

    logic [PC_W-1:0]   pc;
    logic [OPC_W-1:0]  op_q, op_c;
    logic [REG_W-1:0]  rf_q, rf_c, rs_q, rs_c;
    logic [PC_W-1:0]   pc0_q, pc0_c;
    logic [WORD_W-1:0] ext1_q, ext1_c;
    logic [PC_W-1:0]   target_c;
    logic [WORD_W-1:0] imm_c;
    logic              global_c;

    assign advance = !fetch_stall_i;

    insn_len_decode u_len (
        .opcode_i (fetch_word_i[WORD_W-1 -: OPC_W]),
        .len_o    (op_len)
    );

    insn_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (advance),
        .op_len_i    (op_len),
        .in_opcode_o (in_opcode),
        .take_ext1_o (take_ext1),
        .done_o      (done),
        .cur_len_o   (cur_len)
    );

    insn_pc_ctr #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .pc_o      (pc)
    );

    // capture of first word and first extension word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            rf_q   <= '0;
            rs_q   <= '0;
            pc0_q  <= '0;
            ext1_q <= '0;
        end else begin
            if (in_opcode && advance) begin
                op_q  <= fetch_word_i[WORD_W-1 -: OPC_W];
                rf_q  <= fetch_word_i[2*REG_W-1 -: REG_W];
                rs_q  <= fetch_word_i[REG_W-1:0];
                pc0_q <= pc;
            end
            if (take_ext1) begin
                ext1_q <= fetch_word_i;
            end
        end
    end

    // fields of the instruction completing this cycle
    assign op_c   = in_opcode ? fetch_word_i[WORD_W-1 -: OPC_W]  : op_q;
    assign rf_c   = in_opcode ? fetch_word_i[2*REG_W-1 -: REG_W] : rf_q;
    assign rs_c   = in_opcode ? fetch_word_i[REG_W-1:0]          : rs_q;
    assign pc0_c  = in_opcode ? pc : pc0_q;
    assign ext1_c = take_ext1 ? fetch_word_i : ext1_q;

    insn_target_form #(.PC_W(PC_W), .WORD_W(WORD_W)) u_tgt (
        .len_i    (cur_len),
        .pc0_i    (pc0_c),
        .ext1_i   (ext1_c),
        .ext2_i   (fetch_word_i),
        .target_o (target_c),
        .imm_o    (imm_c),
        .global_o (global_c)
    );

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld_o    <= 1'b0;
            dec_opcode_o <= '0;
            dec_rf_o     <= '0;
            dec_rs_o     <= '0;
            dec_len_o    <= 2'd1;
            dec_imm_o    <= '0;
            dec_target_o <= '0;
            dec_global_o <= 1'b0;
            dec_pc_o     <= '0;
        end else begin
            dec_vld_o <= done;
            if (done) begin
                dec_opcode_o <= op_c;
                dec_rf_o     <= rf_c;
                dec_rs_o     <= rs_c;
                dec_len_o    <= cur_len;
                dec_imm_o    <= imm_c;
                dec_target_o <= target_c;
                dec_global_o <= global_c;
                dec_pc_o     <= pc0_c;
            end
        end
    end

    assign fetch_addr_o = pc;

endmodule

// File: rtl/insn_asm_checker.sv
module insn_asm_checker #(
    parameter int PC_W   = 24,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_stall_i,
    input logic [PC_W-1:0]   fetch_addr_o,
    input logic              dec_vld_o,
    input logic [1:0]        dec_len_o,
    input logic [WORD_W-1:0] dec_imm_o,
    input logic [PC_W-1:0]   dec_target_o,
    input logic              dec_global_o,
    input logic [PC_W-1:0]   dec_pc_o
);

    localparam int PAGE_W = PC_W - WORD_W;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stall_i |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(1));

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_i |=> $stable(fetch_addr_o));

    p_no_pulse_after_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall_i |=> !dec_vld_o);

    p_vld_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld_o |-> fetch_addr_o == dec_pc_o + PC_W'(dec_len_o));

    p_local_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_len_o == 2'd2) |->
            (dec_target_o[PC_W-1 -: PAGE_W] == dec_pc_o[PC_W-1 -: PAGE_W] && !dec_global_o));

    p_global_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_global_o) |-> dec_len_o == 2'd3);

    p_oneword_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_len_o == 2'd1) |-> (dec_target_o == '0 && dec_imm_o == '0));

endmodule

bind insn_assembler insn_asm_checker #(.PC_W(PC_W), .WORD_W(WORD_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_stall_i (fetch_stall_i),
    .fetch_addr_o  (fetch_addr_o),
    .dec_vld_o     (dec_vld_o),
    .dec_len_o     (dec_len_o),
    .dec_imm_o     (dec_imm_o),
    .dec_target_o  (dec_target_o),
    .dec_global_o  (dec_global_o),
    .dec_pc_o      (dec_pc_o)
);

// File: tb/test_insn_assembler.sv
module test_insn_assembler;

    localparam logic [23:0] BASE = 24'h03FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_word;
    logic        fetch_stall = 1'b0;
    logic [23:0] fetch_addr;
    logic        dec_vld;
    logic [7:0]  dec_opcode;
    logic [3:0]  dec_rf, dec_rs;
    logic [1:0]  dec_len;
    logic [15:0] dec_imm;
    logic [23:0] dec_target;
    logic        dec_global;
    logic [23:0] dec_pc;

    logic [15:0] prog [0:31];
    logic [23:0] offs;
    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign offs = fetch_addr - BASE;
    always_comb fetch_word = (offs < 24'd32) ? prog[offs[4:0]] : 16'hFF00;

    insn_assembler #(.RESET_PC(BASE)) i_insn_assembler (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_word_i  (fetch_word),
        .fetch_stall_i (fetch_stall),
        .fetch_addr_o  (fetch_addr),
        .dec_vld_o     (dec_vld),
        .dec_opcode_o  (dec_opcode),
        .dec_rf_o      (dec_rf),
        .dec_rs_o      (dec_rs),
        .dec_len_o     (dec_len),
        .dec_imm_o     (dec_imm),
        .dec_target_o  (dec_target),
        .dec_global_o  (dec_global),
        .dec_pc_o      (dec_pc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_insn(input string lreq, input string treq, input int gap,
                               input logic [7:0] op, input logic [3:0] rf, input logic [3:0] rs,
                               input logic [1:0] len, input logic [15:0] imm,
                               input logic [23:0] tgt, input logic glob, input logic [23:0] pc);
        int cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!dec_vld && cnt < 20);
        chk("R8", "cycles to valid", cnt, gap);
        chk("R4", "opcode", dec_opcode, op);
        chk("R4", "rf", dec_rf, rf);
        chk("R4", "rs", dec_rs, rs);
        chk("R4", "first-word pc", dec_pc, pc);
        chk(lreq, "length", dec_len, len);
        chk(treq, "imm", dec_imm, imm);
        chk(treq, "target", dec_target, tgt);
        chk(treq, "global", dec_global, glob);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "addr in reset", fetch_addr, BASE);
        chk("R1", "vld in reset", dec_vld, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_oneword;   // R7, R11
        expect_insn("R7", "R11", 1, 8'hFF, 4'h0, 4'h0, 2'd1, 16'h0, 24'h0, 1'b0, 24'h03FFFE);
    endtask

    task automatic t_local_sector;    // R5, R9: operand word lies in next sector
        expect_insn("R5", "R9", 2, 8'h08, 4'h5, 4'hA, 2'd2, 16'h1234, 24'h031234, 1'b0, 24'h03FFFF);
    endtask

    task automatic t_global_masked;   // R6, R10: upper byte of high word ignored
        expect_insn("R6", "R10", 3, 8'h09, 4'h3, 4'h1, 2'd3, 16'hBEEF, 24'h7FBEEF, 1'b1, 24'h040001);
    endtask

    task automatic t_alu_oneword;     // R7, R8
        expect_insn("R7", "R11", 1, 8'h45, 4'h1, 4'h2, 2'd1, 16'h0, 24'h0, 1'b0, 24'h040004);
    endtask

    task automatic t_stall_midway;    // R2, R3: stall after first word of a three-word op
        @(negedge clk);
        chk("R2", "addr after first word", fetch_addr, 24'h040006);
        chk("R8", "vld not repeated", dec_vld, 1'b0);
        fetch_stall = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3", "addr held", fetch_addr, 24'h040006);
            chk("R3", "no vld while stalled", dec_vld, 1'b0);
        end
        fetch_stall = 1'b0;
        expect_insn("R6", "R10", 2, 8'hC5, 4'h0, 4'h0, 2'd3, 16'h3456, 24'h123456, 1'b1, 24'h040005);
    endtask

    task automatic t_branch_local;    // R5, R9
        expect_insn("R5", "R9", 2, 8'h86, 4'h3, 4'h4, 2'd2, 16'h0100, 24'h040100, 1'b0, 24'h040008);
    endtask

    task automatic t_constant;        // R5, R9
        expect_insn("R5", "R9", 2, 8'h0C, 4'h7, 4'h0, 2'd2, 16'hFFFF, 24'h04FFFF, 1'b0, 24'h04000A);
    endtask

    task automatic t_unassigned;      // R7
        expect_insn("R7", "R11", 1, 8'h77, 4'h0, 4'h0, 2'd1, 16'h0, 24'h0, 1'b0, 24'h04000C);
    endtask

    task automatic t_global_jump;     // R6, R10
        expect_insn("R6", "R10", 3, 8'hC1, 4'h0, 4'h0, 2'd3, 16'h0000, 24'hFF0000, 1'b1, 24'h04000D);
    endtask

    task automatic t_tail;            // R8: back-to-back one-word ops
        expect_insn("R7", "R11", 1, 8'hFF, 4'h0, 4'h0, 2'd1, 16'h0, 24'h0, 1'b0, 24'h040010);
        expect_insn("R7", "R11", 1, 8'hFF, 4'h0, 4'h0, 2'd1, 16'h0, 24'h0, 1'b0, 24'h040011);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) prog[i] = 16'hFF00;
        prog[0]  = 16'hFF00;
        prog[1]  = 16'h085A; prog[2]  = 16'h1234;
        prog[3]  = 16'h0931; prog[4]  = 16'hAB7F; prog[5]  = 16'hBEEF;
        prog[6]  = 16'h4512;
        prog[7]  = 16'hC500; prog[8]  = 16'h0012; prog[9]  = 16'h3456;
        prog[10] = 16'h8634; prog[11] = 16'h0100;
        prog[12] = 16'h0C70; prog[13] = 16'hFFFF;
        prog[14] = 16'h7700;
        prog[15] = 16'hC100; prog[16] = 16'h00FF; prog[17] = 16'h0000;
        t_reset();
        t_first_oneword();
        t_local_sector();
        t_global_masked();
        t_alu_oneword();
        t_stall_midway();
        t_branch_local();
        t_constant();
        t_unassigned();
        t_global_jump();
        t_tail();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule